// File: doc/BRIEF.md
# Keyboard Controller Host Mailbox

This block is a byte-wide mailbox that sits between a host register port and an embedded controller CPU, in the style of a classic PC keyboard controller. The host deposits bytes into an inbound register, which the CPU collects. The CPU deposits bytes into an outbound register, which the host collects. Two full flags show when each buffer holds a byte. They set and clear by themselves from the accesses of the two sides, so neither side needs any extra handshake.

The host sees a status byte. It holds both full flags and a marker that records whether the last host write went to the command address or the data address. The CPU gets an interrupt. The interrupt is not a latched event: it is high whenever the inbound buffer is full and the interrupt enable is high. Reading the inbound byte therefore acknowledges the interrupt. Both ports are plain synchronous strobes. Read data is combinational from the held registers, and flag updates take effect at the next clock edge.

Top module: `kbc_host_mailbox`

## Requirements
- R1: A host write (`hostWr`) stores `hostWrData` into the inbound register and sets the inbound-full flag from the next cycle on. The stored byte appears on `cpuRdData`.
- R2: `cpuIrq` is high exactly when the inbound-full flag is set and `irqEnable` is high.
- R3: A CPU read (`cpuRd`) without a simultaneous host write clears the inbound-full flag at the next edge. `cpuIrq` drops with it, and no other acknowledge is needed.
- R4: A CPU write (`cpuWr`) stores `cpuWrData` into the outbound register and sets the outbound-full flag. While `hostCmdSel` is 0, `hostRdData` shows the outbound register.
- R5: A host read with `hostCmdSel` = 0 and no simultaneous CPU write clears the outbound-full flag at the next edge.
- R6: After synchronous reset (`rstN` low at a clock edge), the status byte is 00h and `cpuIrq` is low. The data registers are not reset.
- R7: While `hostCmdSel` = 1, `hostRdData` shows the status byte. Bit 0 is outbound-full. Bit 1 is inbound-full. Bit 3 is 1 if the last host write had `hostCmdSel` = 1 and 0 if it had `hostCmdSel` = 0. Bits 2 and 7:4 read 0.
- R8: When a setting access and a clearing access hit the same flag in the same cycle, the set wins. This covers a host write with a CPU read, and a CPU write with a host data read. The register takes the new byte.
- R9: A host read with `hostCmdSel` = 1 changes no flag.
- R10: A write into a buffer that is already full overwrites the byte and leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostCmdSel | input | 1 | Host address select: 1 = command/status, 0 = data |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Status byte or outbound register, chosen by hostCmdSel |
| cpuWr | input | 1 | CPU write strobe for the outbound register |
| cpuRd | input | 1 | CPU read strobe for the inbound register |
| cpuWrData | input | 8 | CPU write byte |
| cpuRdData | output | 8 | Inbound register contents |
| irqEnable | input | 1 | CPU interrupt enable |
| cpuIrq | output | 1 | CPU interrupt, level while the inbound buffer is full |

## Verification
A corrupted flag shows in the status byte and, for the inbound flag, on `cpuIrq` as well. It appears in the cycle after the access that caused it, because the flags are the only state between the strobes and the ports. A lost or stale byte shows directly on `cpuRdData` or `hostRdData` one cycle after the write. The sweeps therefore read the status byte and the data outputs after every single access. They also target the collision cycles and the overwrite-while-full cases, where a wrong priority between set and clear would otherwise stay hidden.

// File: rtl/kbc_mbx_pkg.sv
package kbc_mbx_pkg;
  localparam int STAT_OBF = 0;
  localparam int STAT_IBF = 1;
  localparam int STAT_CMD = 3;

  typedef struct packed {
    logic loadIn;
    logic loadOut;
  } mbxStrobe_t;
endpackage

// File: rtl/kbc_mbx_ctrl.sv
module kbc_mbx_ctrl
  import kbc_mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic       hostCmdSel,
  input  logic       cpuWr,
  input  logic       cpuRd,
  input  logic       irqEnable,
  output mbxStrobe_t strobe,
  output logic       ibfFlag,
  output logic       obfFlag,
  output logic       cmdFlag,
  output logic       cpuIrq
);
  logic hostDataRead;

  assign hostDataRead   = hostRd & ~hostCmdSel;
  assign strobe.loadIn  = hostWr;
  assign strobe.loadOut = cpuWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ibfFlag <= 1'b0;
      obfFlag <= 1'b0;
      cmdFlag <= 1'b0;
    end else begin
      // a setting access takes priority over a clearing one
      if (hostWr)           ibfFlag <= 1'b1;
      else if (cpuRd)       ibfFlag <= 1'b0;
      if (cpuWr)            obfFlag <= 1'b1;
      else if (hostDataRead) obfFlag <= 1'b0;
      if (hostWr)           cmdFlag <= hostCmdSel;
    end
  end

  assign cpuIrq = ibfFlag & irqEnable;
endmodule

// File: rtl/kbc_mbx_data.sv
module kbc_mbx_data
  import kbc_mbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  mbxStrobe_t        strobe,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic              hostCmdSel,
  input  logic              ibfFlag,
  input  logic              obfFlag,
  input  logic              cmdFlag,
  output logic [DATA_W-1:0] statusWord,
  output logic [DATA_W-1:0] hostRdData,
  output logic [DATA_W-1:0] cpuRdData
);
  logic [DATA_W-1:0] inReg;
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk) begin
    if (strobe.loadIn)  inReg  <= hostWrData;
    if (strobe.loadOut) outReg <= cpuWrData;
  end

  always_comb begin
    statusWord           = '0;
    statusWord[STAT_OBF] = obfFlag;
    statusWord[STAT_IBF] = ibfFlag;
    statusWord[STAT_CMD] = cmdFlag;
  end

  assign hostRdData = hostCmdSel ? statusWord : outReg;
  assign cpuRdData  = inReg;
endmodule

// File: rtl/kbc_host_mailbox.sv
module kbc_host_mailbox
  import kbc_mbx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic              hostCmdSel,
  input  logic [DATA_W-1:0] hostWrData,
  output logic [DATA_W-1:0] hostRdData,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [DATA_W-1:0] cpuWrData,
  output logic [DATA_W-1:0] cpuRdData,
  input  logic              irqEnable,
  output logic              cpuIrq
);
  mbxStrobe_t        strobe;
  logic              ibfFlag;
  logic              obfFlag;
  logic              cmdFlag;
  logic [DATA_W-1:0] statusWord;

  kbc_mbx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostCmdSel(hostCmdSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .irqEnable(irqEnable), .strobe(strobe), .ibfFlag(ibfFlag),
    .obfFlag(obfFlag), .cmdFlag(cmdFlag), .cpuIrq(cpuIrq)
  );

  kbc_mbx_data #(.DATA_W(DATA_W)) uData (
    .clk(clk), .strobe(strobe), .hostWrData(hostWrData),
    .cpuWrData(cpuWrData), .hostCmdSel(hostCmdSel), .ibfFlag(ibfFlag),
    .obfFlag(obfFlag), .cmdFlag(cmdFlag), .statusWord(statusWord),
    .hostRdData(hostRdData), .cpuRdData(cpuRdData)
  );
endmodule

// File: rtl/kbc_mbx_checker.sv
module kbc_mbx_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWr,
  input logic              hostRd,
  input logic              hostCmdSel,
  input logic [DATA_W-1:0] hostWrData,
  input logic              cpuWr,
  input logic              cpuRd,
  input logic [DATA_W-1:0] cpuRdData,
  input logic              irqEnable,
  input logic              cpuIrq,
  input logic [DATA_W-1:0] statusWord
);
  AST_IBF_SET: assert property (@(posedge clk) disable iff (!rstN)
    hostWr |=> statusWord[1] && cpuRdData == $past(hostWrData)); // R1
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    cpuIrq == (statusWord[1] && irqEnable)); // R2
  AST_IBF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !hostWr) |=> !statusWord[1] && !cpuIrq); // R3
  AST_OBF_SET: assert property (@(posedge clk) disable iff (!rstN)
    cpuWr |=> statusWord[0]); // R4
  AST_OBF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !hostCmdSel && !cpuWr) |=> !statusWord[0]); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[2] == 1'b0 && statusWord[DATA_W-1:4] == '0); // R7
  AST_STATUS_NOSIDE: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostCmdSel && !hostWr && !cpuWr && !cpuRd) |=> $stable(statusWord)); // R9
endmodule

bind kbc_host_mailbox kbc_mbx_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
  .hostCmdSel(hostCmdSel), .hostWrData(hostWrData), .cpuWr(cpuWr),
  .cpuRd(cpuRd), .cpuRdData(cpuRdData), .irqEnable(irqEnable),
  .cpuIrq(cpuIrq), .statusWord(statusWord)
);

// File: tb/tb_kbc_host_mailbox.sv
`timescale 1ns/1ps
module tb_kbc_host_mailbox;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       hostWr = 0, hostRd = 0, hostCmdSel = 0;
  logic [7:0] hostWrData = 0, cpuWrData = 0;
  logic [7:0] hostRdData, cpuRdData;
  logic       cpuWr = 0, cpuRd = 0, irqEnable = 0;
  logic       cpuIrq;
  int         nChk = 0, nBad = 0;
  bit         done = 0;
  logic       mIbf = 0, mObf = 0, mCmd = 0;

  always #4 clk = ~clk;

  kbc_host_mailbox dut (
    .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
    .hostCmdSel(hostCmdSel), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .irqEnable(irqEnable), .cpuIrq(cpuIrq)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expStat();
    return {4'b0, mCmd, 1'b0, mIbf, mObf};
  endfunction

  task automatic peekStatus(string tag);
    hostCmdSel = 1; #1;
    chk(tag, hostRdData, expStat());
    chk({tag, " irq"}, {7'b0, cpuIrq}, {7'b0, mIbf & irqEnable});
  endtask

  task automatic hostWrite(logic cmd, logic [7:0] d);
    hostWr = 1; hostCmdSel = cmd; hostWrData = d;
    step(); hostWr = 0; mIbf = 1; mCmd = cmd;
  endtask

  task automatic cpuRead();
    cpuRd = 1; step(); cpuRd = 0; mIbf = 0;
  endtask

  task automatic cpuWrite(logic [7:0] d);
    cpuWr = 1; cpuWrData = d; step(); cpuWr = 0; mObf = 1;
  endtask

  task automatic hostDataRead();
    hostRd = 1; hostCmdSel = 0; step(); hostRd = 0; mObf = 0;
  endtask

  initial begin
    irqEnable = 1;
    repeat (3) step();
    peekStatus("R6 reset status");
    rstN = 1; step();
    peekStatus("R6 status after release");

    // inbound sweep: every byte value, both address selects, both enables
    for (int v = 0; v < 256; v++) begin
      irqEnable = v[0];
      hostWrite(v[1], v[7:0]);
      peekStatus("R1 R2 R7 status after host write");
      chk("R1 inbound byte", cpuRdData, v[7:0]);
      if (v % 16 == 5) begin
        hostWrite(~v[1], ~v[7:0]);
        peekStatus("R10 status after overwrite");
        chk("R10 inbound overwrite", cpuRdData, ~v[7:0]);
      end
      cpuRead();
      peekStatus("R3 status after cpu read");
    end

    // outbound sweep
    irqEnable = 1;
    for (int v = 0; v < 256; v++) begin
      cpuWrite(v[7:0]);
      hostCmdSel = 0; #1;
      chk("R4 outbound byte", hostRdData, v[7:0]);
      peekStatus("R4 status after cpu write");
      hostRd = 1; hostCmdSel = 1; step(); hostRd = 0;
      peekStatus("R9 status after status read");
      if (v % 16 == 9) begin
        cpuWrite(~v[7:0]);
        hostCmdSel = 0; #1;
        chk("R10 outbound overwrite", hostRdData, ~v[7:0]);
        peekStatus("R10 outbound flag kept");
      end
      hostDataRead();
      peekStatus("R5 status after host data read");
    end

    // collisions
    hostWrite(0, 8'hA5);
    hostWr = 1; hostCmdSel = 0; hostWrData = 8'h3C; cpuRd = 1; #1;
    chk("R8 cpu sees old byte in collision", cpuRdData, 8'hA5);
    step(); hostWr = 0; cpuRd = 0; mIbf = 1; mCmd = 0;
    peekStatus("R8 inbound set wins");
    chk("R8 new inbound byte", cpuRdData, 8'h3C);
    cpuRead();
    cpuWrite(8'h11);
    cpuWr = 1; cpuWrData = 8'h77; hostRd = 1; hostCmdSel = 0; #1;
    chk("R8 host sees old byte in collision", hostRdData, 8'h11);
    step(); cpuWr = 0; hostRd = 0; mObf = 1;
    peekStatus("R8 outbound set wins");
    hostCmdSel = 0; #1;
    chk("R8 new outbound byte", hostRdData, 8'h77);

    // reset mid-traffic
    hostWrite(1, 8'h5A);
    rstN = 0; step(); rstN = 1; mIbf = 0; mObf = 0; mCmd = 0;
    peekStatus("R6 status after reset with both full");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule